// File: doc/BRIEF.md
# Target Time and Pulse Output Unit

This block watches the free-running system time, a seconds count and a binary subseconds count, and turns it into two timing events. The first is a one-shot alarm. Software programs a target seconds and subseconds value and arms the comparator. The first clock on which the system time is at or past the target sets a sticky status flag and disarms the comparator. Reading the status register reports the flag and clears it. An interrupt line follows the flag when the interrupt enable is set.

The second event is a pulse output whose rate is a programmable power of two. When the exponent is zero, the output is a single-cycle pulse each time the seconds count changes. For any other exponent it is a square wave taken from one bit of the subseconds count. The block does not contain the time counter.

Top module: `time_event_unit`

## Requirements
- R1: After reset, irq and pps_out are 0 and every register reads 0.
- R2: Reads are combinational on reg_addr. Address 0 holds the target seconds (32 bits). Address 1 holds the target subseconds: write bits [30:0] are kept and bit 31 reads 0. Address 2 is control: bit 0 arms, bit 1 enables the interrupt. Address 3 is status, with the flag in bit 0. Address 4 holds the pulse exponent in bits [4:0]. Addresses 5 to 7 read 0.
- R3: While armed, if {sys_sec, sys_subsec} is greater than or equal to {target seconds, target subseconds}, the flag is 1 from the next clock edge on.
- R4: A trigger clears the arm bit on the same edge, so each arming yields one event. A control write in the trigger cycle takes effect over the auto-clear.
- R5: A read of address 3 returns the flag and clears it at the following edge. A trigger in the same cycle leaves the flag set.
- R6: irq is 1 exactly when both the flag and the interrupt enable bit are 1.
- R7: While unarmed, the time reaching or passing the target leaves the flag unchanged.
- R8: A time jump from below the target to beyond it sets the flag on the edge that samples the new time, with no intermediate equal value needed.
- R9: With exponent 0, pps_out is 1 for one cycle, one edge after sys_sec differs from its value on the previous edge. The first sample after reset never pulses.
- R10: With exponent n from 1 to 31, pps_out equals sys_subsec bit (31 - n) as sampled at the previous edge.
- R11: Writes to address 4 keep only bits [4:0]. Writes to address 3 and to unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_sec | input | 32 | System time seconds |
| sys_subsec | input | 31 | System time binary subseconds |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt line |
| pps_out | output | 1 | Pulse output |

## Verification
The bench goes after four corner cases. The first is a time jump that skips the target value outright; an equality-only comparator would never fire on it. The second is a status read landing on the trigger cycle; a design with clear priority would lose the event. The third is the cycles after a trigger with time still past the target; a design that forgets to disarm would re-fire after each read. The fourth is the pulse output at exponents 0, 1, 5 and 31. There an off-by-one bit select produces the wrong rate, and missing the reset qualification produces a spurious first pulse. An upper-bit write to the exponent field would also select the wrong bit.

// File: rtl/tev_pkg.sv
package tev_pkg;
    localparam int ADDR_W      = 3;
    localparam logic [ADDR_W-1:0] A_TGT_SEC = 3'd0;
    localparam logic [ADDR_W-1:0] A_TGT_SUB = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PPS     = 3'd4;
    localparam int CTRL_ARM_BIT = 0;
    localparam int CTRL_IEN_BIT = 1;
endpackage

// File: rtl/tev_cmp.sv
module tev_cmp #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic [SEC_W-1:0] now_sec,
    input  logic [SUB_W-1:0] now_sub,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [SUB_W-1:0] tgt_sub,
    output logic             at_or_past
);
    localparam int T_W = SEC_W + SUB_W;
    logic [T_W-1:0] now_t;
    logic [T_W-1:0] tgt_t;

    always_comb begin
        now_t      = {now_sec, now_sub};
        tgt_t      = {tgt_sec, tgt_sub};
        at_or_past = (now_t >= tgt_t);
    end
endmodule

// File: rtl/tev_pps.sv
module tev_pps #(
    parameter int SEC_W  = 32,
    parameter int SUB_W  = 31,
    parameter int FREQ_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  sec,
    input  logic [SUB_W-1:0]  sub,
    input  logic [FREQ_W-1:0] freq,
    output logic              pps
);
    typedef struct packed {
        logic [SEC_W-1:0] prev_sec;
        logic             seen;
        logic             out;
    } pps_st_t;

    pps_st_t st_d, st_q;
    logic [SUB_W-1:0] shifted;

    always_comb begin
        st_d          = st_q;
        shifted       = sub >> (SUB_W - 32'(freq));
        st_d.prev_sec = sec;
        st_d.seen     = 1'b1;
        if (freq == '0) begin
            st_d.out = st_q.seen && (sec != st_q.prev_sec);
        end else begin
            st_d.out = shifted[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pps = st_q.out;
endmodule

// File: rtl/time_event_unit.sv
module time_event_unit #(
    parameter int SEC_W  = 32,
    parameter int SUB_W  = 31,
    parameter int FREQ_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SEC_W-1:0]           sys_sec,
    input  logic [SUB_W-1:0]           sys_subsec,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [tev_pkg::ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic                       irq,
    output logic                       pps_out
);
    import tev_pkg::*;

    typedef struct packed {
        logic [SEC_W-1:0]  tgt_sec;
        logic [SUB_W-1:0]  tgt_sub;
        logic              armed;
        logic              irq_en;
        logic              flag;
        logic [FREQ_W-1:0] freq;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    reached;
    logic    hit;

    tev_cmp #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cmp (
        .now_sec    (sys_sec),
        .now_sub    (sys_subsec),
        .tgt_sec    (st_q.tgt_sec),
        .tgt_sub    (st_q.tgt_sub),
        .at_or_past (reached)
    );

    tev_pps #(.SEC_W(SEC_W), .SUB_W(SUB_W), .FREQ_W(FREQ_W)) u_pps (
        .clk   (clk),
        .rst_n (rst_n),
        .sec   (sys_sec),
        .sub   (sys_subsec),
        .freq  (st_q.freq),
        .pps   (pps_out)
    );

    always_comb begin
        st_d = st_q;
        hit  = st_q.armed && reached;
        if (hit) begin
            st_d.armed = 1'b0;
            st_d.flag  = 1'b1;
        end else if (reg_rd && reg_addr == A_STATUS) begin
            st_d.flag = 1'b0;
        end
        if (reg_wr) begin
            case (reg_addr)
                A_TGT_SEC: st_d.tgt_sec = reg_wdata[SEC_W-1:0];
                A_TGT_SUB: st_d.tgt_sub = reg_wdata[SUB_W-1:0];
                A_CTRL: begin
                    st_d.armed  = reg_wdata[CTRL_ARM_BIT];
                    st_d.irq_en = reg_wdata[CTRL_IEN_BIT];
                end
                A_PPS:     st_d.freq = reg_wdata[FREQ_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_TGT_SEC: reg_rdata[SEC_W-1:0] = st_q.tgt_sec;
            A_TGT_SUB: reg_rdata[SUB_W-1:0] = st_q.tgt_sub;
            A_CTRL: begin
                reg_rdata[CTRL_ARM_BIT] = st_q.armed;
                reg_rdata[CTRL_IEN_BIT] = st_q.irq_en;
            end
            A_STATUS:  reg_rdata[0] = st_q.flag;
            A_PPS:     reg_rdata[FREQ_W-1:0] = st_q.freq;
            default: ;
        endcase
    end

    assign irq = st_q.flag & st_q.irq_en;
endmodule

// File: rtl/tev_chk.sv
module tev_chk #(
    parameter int SEC_W  = 32,
    parameter int SUB_W  = 31,
    parameter int FREQ_W = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [tev_pkg::ADDR_W-1:0] reg_addr,
    input logic [SEC_W-1:0]           sys_sec,
    input logic [SUB_W-1:0]           sys_subsec,
    input logic [SEC_W-1:0]           tgt_sec,
    input logic [SUB_W-1:0]           tgt_sub,
    input logic                       armed,
    input logic                       flag,
    input logic [FREQ_W-1:0]          freq,
    input logic                       pps_out
);
    logic ge;
    assign ge = ({sys_sec, sys_subsec} >= {tgt_sec, tgt_sub});

    assert_ge_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ge) |=> flag);

    assert_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && !$past(reg_wr)) |-> !armed);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == tev_pkg::A_STATUS && !(armed && ge)) |=> !flag);

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !flag) |=> !flag);

    assert_square_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (freq != '0) |=> (pps_out == $past(sys_subsec[SUB_W - 32'(freq)])));
endmodule

bind time_event_unit tev_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W), .FREQ_W(FREQ_W)) u_tev_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .sys_sec    (sys_sec),
    .sys_subsec (sys_subsec),
    .tgt_sec    (st_q.tgt_sec),
    .tgt_sub    (st_q.tgt_sub),
    .armed      (st_q.armed),
    .flag       (st_q.flag),
    .freq       (st_q.freq),
    .pps_out    (pps_out)
);

// File: tb/tb_time_event_unit.sv
module tb_time_event_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sys_sec = '0;
    logic [30:0] sys_subsec = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        pps_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    longint unsigned t_sec = 0, t_sub = 0, t_inc = 0;
    localparam longint unsigned SUBWRAP = 64'h8000_0000;

    longint unsigned m_tsec = 0, m_tsub = 0, m_psec = 0;
    bit m_arm = 0, m_en = 0, m_flag = 0, m_pps = 0, m_pv = 0;
    int m_freq = 0;

    time_event_unit dut (
        .clk(clk), .rst_n(rst_n), .sys_sec(sys_sec), .sys_subsec(sys_subsec),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .pps_out(pps_out)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, string what, longint unsigned got, longint unsigned exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic longint unsigned model_read(int a);
        case (a)
            0: return m_tsec;
            1: return m_tsub;
            2: return {62'd0, m_en, m_arm};
            3: return {63'd0, m_flag};
            4: return longint'(m_freq);
            default: return 0;
        endcase
    endfunction

    task automatic model_clock();
        longint unsigned nowv, tgtv;
        bit hit, np;
        nowv = (t_sec << 31) | t_sub;
        tgtv = (m_tsec << 31) | m_tsub;
        hit  = m_arm && (nowv >= tgtv);
        if (m_freq == 0) np = m_pv && (t_sec != m_psec);
        else np = ((t_sub >> (31 - m_freq)) & 1) != 0;
        m_pps = np; m_psec = t_sec; m_pv = 1;
        if (hit) begin m_flag = 1; m_arm = 0; end
        else if (reg_rd && reg_addr == 3) m_flag = 0;
        if (reg_wr) begin
            case (int'(reg_addr))
                0: m_tsec = reg_wdata;
                1: m_tsub = reg_wdata & 32'h7FFF_FFFF;
                2: begin m_arm = reg_wdata[0]; m_en = reg_wdata[1]; end
                4: m_freq = int'(reg_wdata & 31);
                default: ;
            endcase
        end
    endtask

    task automatic step(string tag);
        sys_sec = t_sec[31:0];
        sys_subsec = t_sub[30:0];
        #2;
        check(tag, "irq", irq, m_flag & m_en);
        check(tag, "pps_out", pps_out, m_pps);
        check(tag, "rdata", reg_rdata, model_read(int'(reg_addr)));
        @(posedge clk);
        model_clock();
        @(negedge clk);
        reg_wr = 0; reg_rd = 0;
        t_sub += t_inc;
        if (t_sub >= SUBWRAP) begin t_sub -= SUBWRAP; t_sec++; end
    endtask

    task automatic wr(int a, logic [31:0] d, string tag);
        reg_wr = 1; reg_addr = 3'(a); reg_wdata = d; step(tag);
    endtask

    task automatic rd(int a, string tag);
        reg_rd = 1; reg_addr = 3'(a); step(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a); #1;
            check("R1", "reset rdata", reg_rdata, 0);
        end
        check("R1", "reset irq", irq, 0);
        check("R1", "reset pps", pps_out, 0);
        rst_n = 1;
        // R2 and R11: register map
        wr(0, 32'd5, "R2");
        wr(1, 32'hFFFF_0100, "R2");
        rd(1, "R2");
        wr(1, 32'h0000_0100, "R2");
        wr(4, 32'hFFFF_FFE3, "R11");
        rd(4, "R11");
        wr(3, 32'hFFFF_FFFF, "R11");
        wr(6, 32'hFFFF_FFFF, "R11");
        rd(3, "R11");
        rd(6, "R2");
        wr(4, 32'd0, "R2");
        // R3, R4, R6: armed crossing
        t_sec = 4; t_sub = 0; t_inc = 64'h1000_0000;
        wr(2, 32'd3, "R3");
        rd(2, "R3");
        idle(12, "R3");
        rd(2, "R4");
        idle(4, "R4");
        rd(3, "R5");
        idle(4, "R4");
        rd(3, "R5");
        // R7: unarmed past target
        wr(2, 32'd2, "R7");
        idle(6, "R7");
        rd(3, "R7");
        // R8: jump past target
        wr(0, 32'd100, "R8");
        wr(1, 32'd0, "R8");
        t_sec = 10; t_inc = 0;
        wr(2, 32'd3, "R8");
        idle(3, "R8");
        t_sec = 200; t_sub = 7;
        idle(3, "R8");
        rd(3, "R8");
        // R5: read in trigger cycle, set wins
        wr(0, 32'd300, "R5");
        wr(2, 32'd1, "R5");
        t_sec = 301;
        rd(3, "R5");
        rd(3, "R5");
        rd(3, "R5");
        // R6: flag with interrupt disabled
        wr(2, 32'd1, "R6");
        t_sec = 400;
        idle(2, "R6");
        rd(3, "R6");
        // R4: control write in trigger cycle overrides clear
        wr(0, 32'd500, "R4");
        t_sec = 600;
        wr(2, 32'd1, "R4");
        wr(2, 32'd3, "R4");
        idle(2, "R4");
        rd(2, "R4");
        rd(3, "R4");
        wr(2, 32'd0, "R4");
        // R9: exponent 0 pulses on seconds change
        t_inc = 64'h1000_0000;
        wr(4, 32'd0, "R9");
        idle(30, "R9");
        // R10: square waves
        wr(4, 32'd1, "R10");
        idle(24, "R10");
        t_inc = 64'h0123_4567;
        wr(4, 32'd5, "R10");
        idle(40, "R10");
        wr(4, 32'd31, "R10");
        idle(20, "R10");
        // R9: first sample after reset never pulses
        rst_n = 0;
        m_tsec = 0; m_tsub = 0; m_arm = 0; m_en = 0; m_flag = 0; m_freq = 0; m_pps = 0; m_pv = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        t_sec = 77; t_inc = 0;
        idle(4, "R9");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule